// File: doc/BRIEF.md
# Banked Ping-Pong Product Store

This block is the scratch memory shared by one row of processing elements in a fully-connected layer engine that reuses multiplications. A multiplier phase computes the product of each input with each of its distinct weights and writes it here. Each element of the row then fetches the products it needs by naming an input slot and a product index, and adds them up elsewhere. Entries are 16 bits wide, and each input slot reserves room for the full range of product indices, so the worst case of one product per possible weight value always fits.

The storage is split into one bank per requester. Input slot `s` lives in bank `s mod N_REQ` at row `s div N_REQ`. Requesters that begin on different slots therefore usually hit different banks. When two requests do meet on the same bank in the same cycle, the lower-numbered requester is served and the other sees `rd_ready` low and holds its request.

Every bank holds two halves. One half is read while the other is being filled for the next block. A swap request exchanges the roles of the two halves. It is honoured only once the writer has reported its block complete and every reader has reported that it is finished with the current half.

Top module: `prod_store`

## Requirements
- R1: After reset the read half is 0 (`rd_half` = 0), every `rd_valid` bit is low and `swap_ok` is low.
- R2: A write with `wr_en` high stores `wr_data` for (`wr_slot`, `wr_idx`) in the half that is not being read (half `~rd_half`). After the next swap, reading that slot and index returns the written value.
- R3: A request accepted in cycle t (`rd_req[k]` and `rd_ready[k]` high) gives `rd_valid[k]` high in cycle t+1. In that cycle `rd_data[k]` holds the entry of the half that was the read half in cycle t.
- R4: Slot `s` belongs to bank `s mod N_REQ`. A request is accepted in the same cycle whenever no lower-numbered requester targets the same bank in that cycle.
- R5: When several requests target one bank in one cycle, only the lowest-numbered of them has `rd_ready` high. The others have `rd_ready` low.
- R6: A request that lost arbitration and is held unchanged is accepted as soon as no lower-numbered request targets its bank, and it returns the correct entry.
- R7: `rd_half` changes only on a cycle where `swap` is high while `swap_ok` is high. A swap issued at any other time is ignored and leaves `rd_half` unchanged.
- R8: `swap_ok` is high exactly when `wr_block_done` has been seen and every `rd_done` bit has been seen since reset or since the last accepted swap. An accepted swap clears all of these records, so `swap_ok` is low in the following cycle.
- R9: Writes into the fill half never change what reads of the current read half return.
- R10: `rd_valid[k]` is low in every cycle that follows a cycle in which requester k was not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one product into the fill half |
| wr_slot | input | $clog2(SLOTS) | Input slot of the written product |
| wr_idx | input | IDX_W | Product index within the slot |
| wr_data | input | DATA_W | Product value |
| wr_block_done | input | 1 | Pulse: the writer has completed the fill half |
| rd_req | input | N_REQ | Read request, one bit per requester |
| rd_slot | input | N_REQ*$clog2(SLOTS) | Slot per requester, requester k at bits k*$clog2(SLOTS) upward |
| rd_idx | input | N_REQ*IDX_W | Product index per requester, requester k at bits k*IDX_W upward |
| rd_ready | output | N_REQ | Request accepted this cycle |
| rd_valid | output | N_REQ | Read data present this cycle |
| rd_data | output | N_REQ*DATA_W | Read data per requester, requester k at bits k*DATA_W upward |
| rd_done | input | N_REQ | Pulse: the requester has finished with the read half |
| swap | input | 1 | Request to exchange the read and fill halves |
| swap_ok | output | 1 | All completion reports are in, so a swap will be taken |
| rd_half | output | 1 | Index of the half currently being read |

## Verification
The bench builds the block with four requesters, eight slots and a 3-bit product index. With these values every bank holds two slot rows in each half, so the row offset in the address is exercised. Every entry of both halves can also be filled and read back within a short run. Three request patterns are used. The first is a rotating pattern with no conflicts. The second sends all four requesters to one bank, which forces a chain of three stalls. The third is a scrambled pattern with mixed collisions. All three run while the fill half is being written. Swap attempts are issued with no completion reports, with only some of them, and with all of them.

// File: rtl/prod_store_pkg.sv
package prod_store_pkg;

   // width of one memoized product
   localparam int PROD_W = 16;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pstore_bank.sv
module pstore_bank #(
   parameter int DEPTH  = 512,
   parameter int ADDR_W = 9,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/pstore_bank_arb.sv
module pstore_bank_arb #(
   parameter int N_REQ   = 4,
   parameter int BANK_W  = 2,
   parameter int ADDR_W  = 9,
   parameter int BANK_ID = 0
) (
   input  logic [N_REQ-1:0]        req,
   input  logic [N_REQ*BANK_W-1:0] banks,
   input  logic [N_REQ*ADDR_W-1:0] addrs,
   output logic [N_REQ-1:0]        grant,
   output logic                    rd_en,
   output logic [ADDR_W-1:0]       rd_addr
);

   logic found;

   // fixed priority: the lowest-numbered requester on this bank wins
   always_comb begin
      grant   = '0;
      rd_addr = '0;
      found   = 1'b0;
      for (int k = 0; k < N_REQ; k++) begin
         if (!found && req[k] && (banks[k*BANK_W +: BANK_W] == BANK_W'(BANK_ID))) begin
            grant[k] = 1'b1;
            rd_addr  = addrs[k*ADDR_W +: ADDR_W];
            found    = 1'b1;
         end
      end
   end

   assign rd_en = found;

endmodule

// File: rtl/pstore_pingpong.sv
module pstore_pingpong #(
   parameter int N_REQ = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_block_done,
   input  logic [N_REQ-1:0] rd_done,
   input  logic             swap,
   output logic             swap_ok,
   output logic             rd_half
);

   logic             wr_fin;
   logic [N_REQ-1:0] rd_fin;

   assign swap_ok = wr_fin && (&rd_fin);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_half <= 1'b0;
         wr_fin  <= 1'b0;
         rd_fin  <= '0;
      end else if (swap && swap_ok) begin
         rd_half <= ~rd_half;
         wr_fin  <= 1'b0;
         rd_fin  <= '0;
      end else begin
         if (wr_block_done) wr_fin <= 1'b1;
         rd_fin <= rd_fin | rd_done;
      end
   end

endmodule

// File: rtl/prod_store.sv
module prod_store
   import prod_store_pkg::*;
#(
   parameter int N_REQ  = 4,
   parameter int SLOTS  = 4,
   parameter int IDX_W  = 8,
   parameter int DATA_W = PROD_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [$clog2(SLOTS)-1:0]          wr_slot,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic                              wr_block_done,
   input  logic [N_REQ-1:0]                  rd_req,
   input  logic [N_REQ*$clog2(SLOTS)-1:0]    rd_slot,
   input  logic [N_REQ*IDX_W-1:0]            rd_idx,
   output logic [N_REQ-1:0]                  rd_ready,
   output logic [N_REQ-1:0]                  rd_valid,
   output logic [N_REQ*DATA_W-1:0]           rd_data,
   input  logic [N_REQ-1:0]                  rd_done,
   input  logic                              swap,
   output logic                              swap_ok,
   output logic                              rd_half
);

   localparam int SLOT_W     = $clog2(SLOTS);
   localparam int BANK_W     = $clog2(N_REQ);
   localparam int ROWS       = SLOTS / N_REQ;
   localparam int ENTRIES    = 1 << IDX_W;
   localparam int HALF_DEPTH = ROWS * ENTRIES;
   localparam int DEPTH      = 2 * HALF_DEPTH;
   localparam int ADDR_W     = $clog2(DEPTH);

   // elaboration-time parameter checks
   if (N_REQ < 2 || !is_pow2(N_REQ)) begin : g_bad_req
      $error("N_REQ must be a power of two of at least 2");
   end
   if (!is_pow2(SLOTS) || SLOTS < N_REQ) begin : g_bad_slots
      $error("SLOTS must be a power of two not below N_REQ");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must be at least 1");
   end
   if (DATA_W != PROD_W) begin : g_bad_data
      $error("DATA_W must equal the product width");
   end

   // half, row and index to the address inside one bank
   function automatic logic [ADDR_W-1:0] map_addr(input logic half,
                                                  input logic [SLOT_W-1:0] slot,
                                                  input logic [IDX_W-1:0] idx);
      int a;
      a = int'(half) * HALF_DEPTH + int'(slot >> BANK_W) * ENTRIES + int'(idx);
      return ADDR_W'(a);
   endfunction

   logic                    half_q;
   logic [ADDR_W-1:0]       wr_addr;
   logic [BANK_W-1:0]       wr_bank;
   logic [N_REQ*BANK_W-1:0] req_banks;
   logic [N_REQ*ADDR_W-1:0] req_addrs;
   logic [N_REQ-1:0]        bank_grant [N_REQ];
   logic [N_REQ-1:0]        bank_re;
   logic [ADDR_W-1:0]       bank_raddr [N_REQ];
   logic [DATA_W-1:0]       bank_rdata [N_REQ];
   logic [N_REQ-1:0]        valid_q;
   logic [BANK_W-1:0]       sel_q [N_REQ];

   pstore_pingpong #(.N_REQ(N_REQ)) u_pingpong (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_block_done (wr_block_done),
      .rd_done       (rd_done),
      .swap          (swap),
      .swap_ok       (swap_ok),
      .rd_half       (half_q)
   );

   assign rd_half = half_q;
   assign wr_bank = wr_slot[BANK_W-1:0];
   assign wr_addr = map_addr(~half_q, wr_slot, wr_idx);

   // per-requester bank and address decode
   for (genvar k = 0; k < N_REQ; k++) begin : g_req
      assign req_banks[k*BANK_W +: BANK_W] = rd_slot[k*SLOT_W +: BANK_W];
      assign req_addrs[k*ADDR_W +: ADDR_W] =
         map_addr(half_q, rd_slot[k*SLOT_W +: SLOT_W], rd_idx[k*IDX_W +: IDX_W]);
      assign rd_data[k*DATA_W +: DATA_W] = bank_rdata[sel_q[k]];
   end

   // one arbiter and one storage array per bank
   for (genvar b = 0; b < N_REQ; b++) begin : g_bank
      pstore_bank_arb #(
         .N_REQ   (N_REQ),
         .BANK_W  (BANK_W),
         .ADDR_W  (ADDR_W),
         .BANK_ID (b)
      ) u_arb (
         .req     (rd_req),
         .banks   (req_banks),
         .addrs   (req_addrs),
         .grant   (bank_grant[b]),
         .rd_en   (bank_re[b]),
         .rd_addr (bank_raddr[b])
      );

      pstore_bank #(
         .DEPTH  (DEPTH),
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W)
      ) u_mem (
         .clk   (clk),
         .we    (wr_en && (wr_bank == BANK_W'(b))),
         .waddr (wr_addr),
         .wdata (wr_data),
         .re    (bank_re[b]),
         .raddr (bank_raddr[b]),
         .rdata (bank_rdata[b])
      );
   end

   always_comb begin
      rd_ready = '0;
      for (int b = 0; b < N_REQ; b++) begin
         rd_ready = rd_ready | bank_grant[b];
      end
   end

   // response tracking: which bank answers each requester next cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int k = 0; k < N_REQ; k++) sel_q[k] <= '0;
      end else begin
         valid_q <= rd_ready;
         for (int k = 0; k < N_REQ; k++) begin
            if (rd_ready[k]) sel_q[k] <= req_banks[k*BANK_W +: BANK_W];
         end
      end
   end

   assign rd_valid = valid_q;

endmodule

// File: rtl/prod_store_chk.sv
module prod_store_chk #(
   parameter int N_REQ = 4,
   parameter int SLOTS = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [N_REQ-1:0]               rd_req,
   input logic [N_REQ*$clog2(SLOTS)-1:0] rd_slot,
   input logic [N_REQ-1:0]               rd_ready,
   input logic [N_REQ-1:0]               rd_valid,
   input logic                           swap,
   input logic                           swap_ok,
   input logic                           rd_half
);

   localparam int SLOT_W = $clog2(SLOTS);
   localparam int BANK_W = $clog2(N_REQ);

   logic [N_REQ-1:0] shadowed;

   // a request is shadowed when a lower-numbered one wants the same bank
   always_comb begin
      shadowed = '0;
      for (int k = 1; k < N_REQ; k++) begin
         for (int j = 0; j < k; j++) begin
            if (rd_req[j] && rd_req[k] &&
                rd_slot[j*SLOT_W +: BANK_W] == rd_slot[k*SLOT_W +: BANK_W])
               shadowed[k] = 1'b1;
         end
      end
   end

   for (genvar k = 0; k < N_REQ; k++) begin : g_chk
      // R5
      loser_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         shadowed[k] |-> !rd_ready[k]);
      // R4
      free_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_req[k] && !shadowed[k]) |-> rd_ready[k]);
      // R3
      resp_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_ready[k] |=> rd_valid[k]);
      // R10
      no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_ready[k] |=> !rd_valid[k]);
   end

   // R7
   swap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_half != $past(rd_half)) |-> $past(swap && swap_ok));

   // R8
   swap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swap && swap_ok) |=> !swap_ok);

endmodule

bind prod_store prod_store_chk #(.N_REQ(N_REQ), .SLOTS(SLOTS)) u_chk (.*);

// File: tb/prod_store_tb_top.sv
`timescale 1ns/1ps
module prod_store_tb_top;

   localparam int N  = 4;
   localparam int S  = 8;
   localparam int IW = 3;
   localparam int SW = 3;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            wr_en;
   logic [SW-1:0]   wr_slot;
   logic [IW-1:0]   wr_idx;
   logic [15:0]     wr_data;
   logic            wr_block_done;
   logic [N-1:0]    rd_req;
   logic [N*SW-1:0] rd_slot;
   logic [N*IW-1:0] rd_idx;
   logic [N-1:0]    rd_ready;
   logic [N-1:0]    rd_valid;
   logic [N*16-1:0] rd_data;
   logic [N-1:0]    rd_done;
   logic            swap;
   logic            swap_ok;
   logic            rd_half;

   always #10 clk = ~clk;

   prod_store #(.N_REQ(N), .SLOTS(S), .IDX_W(IW), .DATA_W(16)) dut_i (.*);

   // behavioural reference state
   logic [15:0] mdl [2][S][1 << IW];
   int          mhalf = 0;
   logic        mwr   = 1'b0;
   logic [N-1:0] mrd  = '0;
   logic [N-1:0] acc;
   logic [N-1:0] waited = '0;
   int n_chk = 0, n_fail = 0;
   int wgen = 0, wcnt = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] wdat(input int g, input int s, input int i);
      return 16'(16'h0a00 + g * 16'h0100 + s * 16'h10 + i);
   endfunction

   task automatic idle();
      wr_en = 0; wr_slot = '0; wr_idx = '0; wr_data = '0; wr_block_done = 0;
      rd_req = '0; rd_slot = '0; rd_idx = '0; rd_done = '0; swap = 0;
   endtask

   // one clock: check accept at mid-cycle, advance model, check results after the edge
   task automatic step();
      logic [N-1:0] er;
      logic [15:0]  ed [N];
      #1;
      for (int k = 0; k < N; k++) begin
         logic blk = 1'b0;
         for (int j = 0; j < k; j++)
            if (rd_req[j] && rd_req[k] && rd_slot[j*SW +: 2] == rd_slot[k*SW +: 2]) blk = 1'b1;
         er[k] = rd_req[k] && !blk;
         if (blk) chk("R5 ready", rd_ready[k], er[k]);
         else if (waited[k]) chk("R6 ready", rd_ready[k], er[k]);
         else chk("R4 ready", rd_ready[k], er[k]);
         ed[k] = mdl[mhalf][rd_slot[k*SW +: SW]][rd_idx[k*IW +: IW]];
         if (blk) waited[k] = 1'b1;
         if (er[k]) waited[k] = 1'b0;
      end
      if (wr_en) mdl[1 - mhalf][wr_slot][wr_idx] = wr_data;
      if (swap && mwr && (&mrd)) begin
         mhalf = 1 - mhalf; mwr = 1'b0; mrd = '0;
      end else begin
         if (wr_block_done) mwr = 1'b1;
         mrd = mrd | rd_done;
      end
      @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
         if (er[k]) begin
            chk("R3 valid", rd_valid[k], 1);
            chk("R3 R2 R9 data", rd_data[k*16 +: 16], ed[k]);
         end else chk("R10 valid", rd_valid[k], 0);
      end
      chk("R7 half", rd_half, mhalf[0]);
      chk("R8 swap_ok", swap_ok, mwr && (&mrd));
      acc = er;
   endtask

   task automatic fill_one();
      if (wcnt < S * (1 << IW)) begin
         wr_en = 1; wr_slot = SW'(wcnt / 8); wr_idx = IW'(wcnt % 8);
         wr_data = wdat(wgen, wcnt / 8, wcnt % 8);
         wcnt++;
      end
   endtask

   // mode 0 rotating banks, mode 1 all on bank 0, mode 2 scrambled
   task automatic run_reads(input int mode, input int nper);
      int cnt [N];
      bit busy = 1'b1;
      for (int k = 0; k < N; k++) cnt[k] = 0;
      while (busy) begin
         idle();
         for (int k = 0; k < N; k++) begin
            int s, i;
            s = (mode == 0) ? (k + cnt[k]) % S :
                (mode == 1) ? 4 * (cnt[k] % 2) :
                              (k * 5 + cnt[k] * 3 + cnt[k] * cnt[k]) % S;
            i = (k * 3 + cnt[k]) % 8;
            rd_req[k] = cnt[k] < nper;
            rd_slot[k*SW +: SW] = SW'(s);
            rd_idx[k*IW +: IW] = IW'(i);
         end
         fill_one();
         step();
         busy = 1'b0;
         for (int k = 0; k < N; k++) begin
            if (acc[k]) cnt[k]++;
            if (cnt[k] < nper) busy = 1'b1;
         end
      end
      idle();
   endtask

   task automatic finish_fill_and_swap();
      while (wcnt < S * (1 << IW)) begin idle(); fill_one(); step(); end
      idle(); wr_block_done = 1; step();
      idle(); rd_done = '1; step();
      idle(); swap = 1; step();
      idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 half", rd_half, 0);
      chk("R1 valid", rd_valid, 0);
      chk("R1 swap_ok", swap_ok, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // fill half 1; a premature swap must be ignored (R7)
      wgen = 1; wcnt = 0;
      while (wcnt < S * (1 << IW)) begin
         idle(); fill_one();
         if (wcnt == 10) swap = 1;
         step();
      end
      idle(); wr_block_done = 1; step();
      idle(); swap = 1; step();              // R7: readers not done
      idle(); rd_done = 4'b0111; step();
      idle(); swap = 1; step();              // R7: one reader still missing
      idle(); rd_done = 4'b1000; step();     // R8: swap_ok rises
      idle(); swap = 1; step();              // accepted swap
      chk("R7 half after swap", rd_half, 1);
      chk("R8 cleared", swap_ok, 0);

      // read half 1 while refilling half 0 (R9)
      wgen = 2; wcnt = 0;
      run_reads(0, 6);
      run_reads(1, 3);
      run_reads(2, 8);
      finish_fill_and_swap();
      chk("R2 half back to 0", rd_half, 0);

      // read refilled half 0 (R2), with new writes into half 1
      wgen = 3; wcnt = 0;
      run_reads(0, 8);
      run_reads(2, 10);
      run_reads(1, 2);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule